// File: doc/BRIEF.md
# I2C GPIO expander core

This block adds eight general purpose pins to a system that reaches them over a two-wire I2C bus. A bus host addresses the block, writes a command byte that selects one of eight internal registers, and then writes or reads data bytes. The register index moves on by one after every data byte and wraps from the last register back to the first. Each pin is set up on its own: as an input or an output, with an output level, an input polarity flip, a pull resistor enable with up or down choice, a bus-hold enable and an interrupt mask.

The block answers on one of two 7-bit addresses. They share their upper six bits (parameter `BASE_ADDR`), and the strap input `addr_sel` supplies the lowest bit. A second, shared broadcast address (parameter `BCAST_ADDR`) lets several such blocks take identical settings in one write. Inputs pass through a two-flop synchronizer. An input pin that is not masked and whose level moves away from the value captured at the last read of the input port pulls the open-drain interrupt line low. The pads are modelled as separate input, output-enable and output-value signals, with the pull and hold control bits brought out as plain outputs. The bus is sampled with the system clock, which must run well above the SCL rate.

Top module: `gpio_expander_core`

## Requirements
- R1: After `rst_n` is released, `pin_oe`, `pin_o`, `pull_en`, `pull_up` and `hold_en` are all zero, `irq_pull` is 0, and every stored register except the mask reads 0x00. The mask register (index 7) reads 0xFF, meaning all pins are masked.
- R2: The block acknowledges an address byte whose upper seven bits equal `{BASE_ADDR[6:1], addr_sel}`, whether the R/W bit (bit 0, 1 = read) is set or clear. Any other address, apart from the broadcast one, gets no acknowledge and has no effect.
- R3: A write to `BCAST_ADDR` is acknowledged and updates the registers. A read addressed to `BCAST_ADDR` is not acknowledged.
- R4: The first byte after a write address is a command byte, and its low three bits select a register. The indices are 0 input port, 1 polarity invert, 2 bus-hold enable, 3 pull enable, 4 pull-up select, 5 direction, 6 output value and 7 interrupt mask. The index increments after each data byte, wrapping from 7 to 0, for both writes and reads.
- R5: A direction bit set to 1 makes that pin an output: `pin_oe` follows the direction register and `pin_o` follows the output-value register.
- R6: Reading index 0 returns the synchronized `pin_i` XOR the polarity-invert register, bit by bit.
- R7: A data byte written to index 0 is discarded. No register changes, and a later read of index 0 still shows the pins.
- R8: `hold_en`, `pull_en` and `pull_up` follow registers 2, 3 and 4 bit for bit (`pull_up` 1 = pull up, 0 = pull down).
- R9: `irq_pull` goes to 1 (line driven low) when a pin that is an input (direction 0) and unmasked (mask 0) differs from the value captured at the last read of index 0. Masked pins and output pins never raise it.
- R10: `irq_pull` returns to 0 when index 0 is read, or when every changed pin returns to its last-read value.
- R11: Asserting `rst_n` low in the middle of a bus transfer restores the R1 state, and the next transfer is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples the bus |
| rst_n | input | 1 | Active-low reset to defaults |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the bus data line low |
| addr_sel | input | 1 | Strap choosing the low address bit |
| pin_i | input | 8 | Pad input levels |
| pin_oe | output | 8 | Pad output enables (1 = drive) |
| pin_o | output | 8 | Pad output levels |
| pull_en | output | 8 | Pull resistor enable per pin |
| pull_up | output | 8 | Pull direction per pin (1 = up) |
| hold_en | output | 8 | Bus-hold enable per pin |
| irq_pull | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The assertions assume that the host moves SDA only while SCL is low, except for start and stop conditions. They also assume that each bus level holds for several system clocks, so that the synchronized edges arrive in order, and that pad inputs stay steady for more than the two-flop synchronizer delay. The bench meets these assumptions by holding every bus quarter-period for eight clocks. It changes pin levels only while the bus is idle and waits ten clocks before it samples the interrupt.

// File: rtl/gpio_exp_pkg.sv
package gpio_exp_pkg;
  localparam int GPIO_W = 8;
  localparam int REG_N  = 8;
  localparam int PTR_W  = $clog2(REG_N);

  typedef enum logic [2:0] {
    RI_IN   = 3'd0,
    RI_INV  = 3'd1,
    RI_HOLD = 3'd2,
    RI_PEN  = 3'd3,
    RI_PUP  = 3'd4,
    RI_DIR  = 3'd5,
    RI_OUT  = 3'd6,
    RI_MASK = 3'd7
  } reg_idx_e;

  typedef enum logic [2:0] {BS_IDLE, BS_RX, BS_ACK, BS_TX, BS_MACK} bus_st_e;
  typedef enum logic [1:0] {RK_ADDR, RK_CMD, RK_DATA} rx_kind_e;

  // value presented for a read of the input port
  function automatic logic [GPIO_W-1:0] port_view(logic [GPIO_W-1:0] pins,
                                                  logic [GPIO_W-1:0] inv);
    return pins ^ inv;
  endfunction

  // pins that should hold the interrupt line low
  function automatic logic [GPIO_W-1:0] irq_pending(logic [GPIO_W-1:0] pins,
                                                    logic [GPIO_W-1:0] seen,
                                                    logic [GPIO_W-1:0] dir,
                                                    logic [GPIO_W-1:0] mask);
    return (pins ^ seen) & ~dir & ~mask;
  endfunction

  // address byte match: own address any direction, broadcast for writes only
  function automatic logic addr_hit(logic [7:0] abyte, logic [6:0] own, logic [6:0] bc);
    return (abyte[7:1] == own) || ((abyte[7:1] == bc) && !abyte[0]);
  endfunction
endpackage

// File: rtl/i2c_target_fe.sv
module i2c_target_fe
  import gpio_exp_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR  = 7'h22,
  parameter logic [6:0] BCAST_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [PTR_W-1:0]  wr_idx,
  output logic [GPIO_W-1:0] wr_data,
  output logic              rd_stb,
  output logic [PTR_W-1:0]  rd_idx,
  input  logic [GPIO_W-1:0] rd_data
);
  localparam int BITS = 8;

  logic [2:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev, load_ev;
  logic [6:0] own_addr;

  bus_st_e             st;
  rx_kind_e            kind;
  logic [BITS-1:0]     sh, tx;
  logic [3:0]          cnt;
  logic [PTR_W-1:0]    ptr;
  logic                rnw, bcast, mack;

  assign own_addr = {BASE_ADDR[6:1], addr_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s    = scl_q[1];
  assign scl_p    = scl_q[2];
  assign sda_s    = sda_q[1];
  assign sda_p    = sda_q[2];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  // a byte is fetched for transmission: after a read address ack, or after host ack
  assign load_ev = scl_fall && !start_ev && !stop_ev &&
                   (((st == BS_ACK) && rnw && (kind == RK_ADDR)) ||
                    ((st == BS_MACK) && mack));
  assign rd_stb = load_ev;
  assign rd_idx = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BS_IDLE;
      kind    <= RK_ADDR;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      ptr     <= '0;
      rnw     <= 1'b0;
      bcast   <= 1'b0;
      mack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_ev) begin
        st     <= BS_RX;
        kind   <= RK_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        bcast  <= 1'b0;
      end else if (stop_ev) begin
        st     <= BS_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          BS_RX: begin
            if (scl_rise && cnt != 4'(BITS)) begin
              sh  <= {sh[BITS-2:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'(BITS)) begin
              cnt <= '0;
              case (kind)
                RK_ADDR: begin
                  if (addr_hit(sh, own_addr, BCAST_ADDR)) begin
                    st     <= BS_ACK;
                    sda_oe <= 1'b1;
                    rnw    <= sh[0];
                    bcast  <= (sh[7:1] == BCAST_ADDR) && (sh[7:1] != own_addr);
                  end else begin
                    st <= BS_IDLE;
                  end
                end
                RK_CMD: begin
                  ptr    <= sh[PTR_W-1:0];
                  st     <= BS_ACK;
                  sda_oe <= 1'b1;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  ptr     <= ptr + 1'b1;
                  st      <= BS_ACK;
                  sda_oe  <= 1'b1;
                end
              endcase
            end
          end
          BS_ACK: begin
            if (load_ev) begin
              tx     <= rd_data;
              ptr    <= ptr + 1'b1;
              sda_oe <= ~rd_data[BITS-1];
              cnt    <= '0;
              st     <= BS_TX;
            end else if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= BS_RX;
              kind   <= (kind == RK_ADDR) ? RK_CMD : RK_DATA;
            end
          end
          BS_TX: begin
            if (scl_fall) begin
              if (cnt == 4'(BITS - 1)) begin
                sda_oe <= 1'b0;
                st     <= BS_MACK;
              end else begin
                cnt    <= cnt + 4'd1;
                tx     <= {tx[BITS-2:0], 1'b0};
                sda_oe <= ~tx[BITS-2];
              end
            end
          end
          BS_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (load_ev) begin
              tx     <= rd_data;
              ptr    <= ptr + 1'b1;
              sda_oe <= ~rd_data[BITS-1];
              cnt    <= '0;
              st     <= BS_TX;
            end else if (scl_fall) begin
              st <= BS_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the data line is only pulled while the block owns a bit slot
  a_r2_sda_owned: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == BS_ACK || st == BS_TX));

  // R3: a broadcast transfer never reaches the transmit phase
  a_r3_no_bcast_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BS_TX) |-> !bcast);

  // R4: each stored data byte leaves the pointer one past its index
  a_r4_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ptr == PTR_W'(wr_idx + 1'b1)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_exp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [GPIO_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  input  logic [GPIO_W-1:0] pins_s,
  output logic [GPIO_W-1:0] rd_data,
  output logic [GPIO_W-1:0] inv_o,
  output logic [GPIO_W-1:0] hold_o,
  output logic [GPIO_W-1:0] pen_o,
  output logic [GPIO_W-1:0] pup_o,
  output logic [GPIO_W-1:0] dir_o,
  output logic [GPIO_W-1:0] out_o,
  output logic [GPIO_W-1:0] mask_o
);
  logic [GPIO_W-1:0] r [REG_N];

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    if (i == int'(RI_IN)) begin : g_ro
      assign r[i] = {GPIO_W{1'b0}};
    end else begin : g_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          r[i] <= (i == int'(RI_MASK)) ? {GPIO_W{1'b1}} : {GPIO_W{1'b0}};
        else if (wr_stb && wr_idx == PTR_W'(i))
          r[i] <= wr_data;
      end
    end
  end

  assign rd_data = (rd_idx == RI_IN) ? port_view(pins_s, r[RI_INV]) : r[rd_idx];

  assign inv_o  = r[RI_INV];
  assign hold_o = r[RI_HOLD];
  assign pen_o  = r[RI_PEN];
  assign pup_o  = r[RI_PUP];
  assign dir_o  = r[RI_DIR];
  assign out_o  = r[RI_OUT];
  assign mask_o = r[RI_MASK];

  // R7: a write aimed at the input port leaves stored state alone
  a_r7_in_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_idx == RI_IN) |=>
      ($stable(r[RI_DIR]) && $stable(r[RI_MASK]) && $stable(r[RI_INV]) && $stable(r[RI_OUT])));

  // R5: pad direction moves only on a bus write
  a_r5_dir_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(dir_o));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_exp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] pin_i,
  input  logic [GPIO_W-1:0] dir,
  input  logic [GPIO_W-1:0] mask,
  input  logic              rd_stb,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [GPIO_W-1:0] pins_s,
  output logic              irq_pull
);
  localparam int SYNC_N = 2;

  logic [GPIO_W-1:0] sync_q [SYNC_N];
  logic [GPIO_W-1:0] seen;
  logic              port_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_N; k++) sync_q[k] <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int k = 1; k < SYNC_N; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign pins_s    = sync_q[SYNC_N-1];
  assign port_read = rd_stb && (rd_idx == RI_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= '0;
      irq_pull <= 1'b0;
    end else begin
      if (port_read) seen <= pins_s;
      irq_pull <= |irq_pending(pins_s, seen, dir, mask) && !port_read;
    end
  end

  // R9: with every pin masked or driven, the line stays released
  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&(mask | dir)) |=> !irq_pull);

  // R10: a read of the input port releases the line on the next cycle
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    port_read |=> !irq_pull);
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core
  import gpio_exp_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR  = 7'h22,
  parameter logic [6:0] BCAST_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              addr_sel,
  input  logic [GPIO_W-1:0] pin_i,
  output logic [GPIO_W-1:0] pin_oe,
  output logic [GPIO_W-1:0] pin_o,
  output logic [GPIO_W-1:0] pull_en,
  output logic [GPIO_W-1:0] pull_up,
  output logic [GPIO_W-1:0] hold_en,
  output logic              irq_pull
);
  logic              wr_stb, rd_stb;
  logic [PTR_W-1:0]  wr_idx, rd_idx;
  logic [GPIO_W-1:0] wr_data, rd_data, pins_s, inv, mask;

  i2c_target_fe #(.BASE_ADDR(BASE_ADDR), .BCAST_ADDR(BCAST_ADDR)) u_fe (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  gpio_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .pins_s(pins_s), .rd_data(rd_data), .inv_o(inv),
    .hold_o(hold_en), .pen_o(pull_en), .pup_o(pull_up), .dir_o(pin_oe),
    .out_o(pin_o), .mask_o(mask)
  );

  gpio_irq u_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .dir(pin_oe), .mask(mask),
    .rd_stb(rd_stb), .rd_idx(rd_idx), .pins_s(pins_s), .irq_pull(irq_pull)
  );

  // R6: the polarity register is observed only through the read path
  logic unused_inv;
  assign unused_inv = ^inv;
endmodule

// File: tb/test_gpio_expander_core.sv
module test_gpio_expander_core;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'h22;
  localparam logic [6:0] A1 = 7'h23;
  localparam logic [6:0] BC = 7'h68;
  // {register index, value}
  localparam logic [15:0] VEC [7] = '{16'h010F, 16'h023C, 16'h03C3, 16'h0481,
                                     16'h05F0, 16'h06A5, 16'h077E};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic addr_sel = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic sda_oe, irq_pull;
  logic [7:0] pin_oe, pin_o, pull_en, pull_up, hold_en;
  wire sda_line = ~(m_low | sda_oe);

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gpio_expander_core i_gpio_expander_core (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .pin_i(pin_i), .pin_oe(pin_oe), .pin_o(pin_o),
    .pull_en(pull_en), .pull_up(pull_up), .hold_en(hold_en), .irq_pull(irq_pull)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; tick(Q);
      scl = 1'b1;    tick(Q);
      scl = 1'b0;    tick(Q);
    end
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda_line;
    scl = 1'b0;   tick(Q);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl = 1'b1; tick(Q);
      b[i] = sda_line;
      scl = 1'b0;
    end
    tick(Q);
    m_low = give_ack; tick(Q);
    scl = 1'b1;       tick(Q);
    scl = 1'b0;
    m_low = 1'b0;     tick(Q);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [2:0] idx,
                           input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    put_byte({a, 1'b0}, k0);
    put_byte({5'd0, idx}, k1);
    put_byte(d, k2);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [2:0] idx,
                          output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    put_byte({a, 1'b0}, k0);
    put_byte({5'd0, idx}, k1);
    bus_start();
    put_byte({a, 1'b1}, k2);
    get_byte(1'b0, d);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ok, k;
    logic [7:0] d, d2;
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state at the pads and in the registers
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_o", pin_o, 8'h00);
    chk("R1 pull_en", pull_en, 8'h00);
    chk("R1 pull_up", pull_up, 8'h00);
    chk("R1 hold_en", hold_en, 8'h00);
    chk("R1 irq", irq_pull, 1'b0);
    reg_read(A0, 3'd7, d, ok);
    chk("R1 mask reads FF", d, 8'hFF);
    reg_read(A0, 3'd5, d, ok);
    chk("R1 dir reads 00", d, 8'h00);

    // R4, R5, R8: table of write then read back, with pad view
    for (int v = 0; v < 7; v++) begin
      reg_write(A0, VEC[v][10:8], VEC[v][7:0], ok);
      chk("R2 write acked", ok, 1'b1);
      reg_read(A0, VEC[v][10:8], d, ok);
      chk("R4 readback", d, VEC[v][7:0]);
      case (VEC[v][10:8])
        3'd2: chk("R8 hold_en", hold_en, VEC[v][7:0]);
        3'd3: chk("R8 pull_en", pull_en, VEC[v][7:0]);
        3'd4: chk("R8 pull_up", pull_up, VEC[v][7:0]);
        3'd5: chk("R5 pin_oe", pin_oe, VEC[v][7:0]);
        3'd6: chk("R5 pin_o", pin_o, VEC[v][7:0]);
        default: ;
      endcase
    end

    // R6: input port view = pins ^ invert (0x96 ^ 0x0F)
    pin_i = 8'h96; tick(10);
    reg_read(A0, 3'd0, d, ok);
    chk("R6 input view", d, 8'h99);

    // R4, R7: burst write from index 6 wraps through 7, 0 (dropped), 1
    bus_start();
    put_byte({A0, 1'b0}, k);
    put_byte(8'h06, k);
    put_byte(8'h11, k);
    put_byte(8'h22, k);
    put_byte(8'h33, k);
    put_byte(8'h44, k);
    bus_stop();
    chk("R4 burst out", pin_o, 8'h11);
    reg_read(A0, 3'd1, d, ok);
    chk("R4 wrap to invert", d, 8'h44);
    reg_read(A0, 3'd0, d, ok);
    chk("R7 input port ignores write", d, 8'h96 ^ 8'h44);
    chk("R7 dir unchanged", pin_oe, 8'hF0);

    // R4: burst read from index 6
    bus_start();
    put_byte({A0, 1'b0}, k);
    put_byte(8'h06, k);
    bus_start();
    put_byte({A0, 1'b1}, k);
    get_byte(1'b1, d);
    get_byte(1'b0, d2);
    bus_stop();
    chk("R4 burst read out", d, 8'h11);
    chk("R4 burst read mask", d2, 8'h22);

    // R2: other strap address is ignored
    bus_start();
    put_byte({A1, 1'b0}, k);
    bus_stop();
    chk("R2 foreign nack", k, 1'b0);
    addr_sel = 1'b1; tick(4);
    reg_write(A1, 3'd5, 8'h0C, ok);
    chk("R2 strap address acked", ok, 1'b1);
    chk("R2 strap write lands", pin_oe, 8'h0C);
    reg_write(A0, 3'd5, 8'h55, ok);
    chk("R2 old address nack", ok, 1'b0);
    chk("R2 no effect", pin_oe, 8'h0C);
    addr_sel = 1'b0; tick(4);

    // R3: broadcast write accepted, broadcast read refused
    reg_write(BC, 3'd5, 8'h0F, ok);
    chk("R3 bcast write ack", ok, 1'b1);
    chk("R3 bcast write lands", pin_oe, 8'h0F);
    bus_start();
    put_byte({BC, 1'b1}, k);
    bus_stop();
    chk("R3 bcast read nack", k, 1'b0);

    // R9, R10: interrupt behaviour
    reg_write(A0, 3'd5, 8'h00, ok);
    reg_write(A0, 3'd1, 8'h00, ok);
    reg_write(A0, 3'd7, 8'hFE, ok);
    pin_i = 8'h00; tick(10);
    reg_read(A0, 3'd0, d, ok);
    tick(10);
    chk("R9 idle irq", irq_pull, 1'b0);
    pin_i = 8'h02; tick(10);
    chk("R9 masked pin quiet", irq_pull, 1'b0);
    pin_i = 8'h03; tick(10);
    chk("R9 unmasked change", irq_pull, 1'b1);
    pin_i = 8'h02; tick(10);
    chk("R10 return clears", irq_pull, 1'b0);
    pin_i = 8'h03; tick(10);
    chk("R9 change again", irq_pull, 1'b1);
    reg_read(A0, 3'd0, d, ok);
    chk("R6 read with irq", d, 8'h03);
    tick(10);
    chk("R10 read clears", irq_pull, 1'b0);
    reg_write(A0, 3'd5, 8'h01, ok);
    pin_i = 8'h02; tick(10);
    chk("R9 output pin quiet", irq_pull, 1'b0);

    // R11: reset in the middle of a transfer
    reg_write(A0, 3'd3, 8'h77, ok);
    bus_start();
    put_byte({A0, 1'b0}, k);
    put_byte(8'h05, k);
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    rst_n = 1'b0; tick(3);
    scl = 1'b0;   tick(Q);
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    rst_n = 1'b1; tick(Q);
    chk("R11 pull_en reset", pull_en, 8'h00);
    chk("R11 pin_oe reset", pin_oe, 8'h00);
    reg_read(A0, 3'd7, d, ok);
    chk("R11 serves after reset", ok, 1'b1);
    chk("R11 mask back to FF", d, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule